// File: doc/BRIEF.md
# Shutdown and wake-up controller

This block sits in the always-on slow-clock domain. Software uses it to put the core supply to sleep and to choose what may bring it back. A register port gives access to four words: a write-only command word, a mode word, a status word that clears when read, and a pin configuration word. A correct command write raises the `shutdown` output. The output falls again when a qualified wake-up event occurs, and that event also produces a one-cycle `wake_req` pulse.

Nine wake-up pins each have an enable and an active level of their own. Each pin is synchronized and then debounced. A pin must first be seen inactive and then stay at its active level for a programmable number of slow-clock samples before it counts. When a pin fires, the status word records which pins were enabled and active at that moment. Pins 0 and 1 can also use a second, very slow debouncer that counts ticks from an external time base. Three internal single-cycle sources (timer, comparator and low-power receiver) can wake the core when their mode bits are set.

Top module: `shwk_ctrl`

## Requirements
- R1: A write to word 0 sets `shutdown` only when bit 0 is 1 and bits 31:24 hold 0xA5. Any other key value leaves `shutdown` unchanged. Word 0 always reads as 0.
- R2: Mode bits 26:24 select the pin debounce length N in synchronized samples: 0→1, 1→3, 2→32, 3→512, 4→4096, and codes 5, 6 and 7 all give 32768. A pin that turns active just before rising edge E0 gives `wake_req` = 1 after edge E(N+1), and not earlier.
- R3: Pin configuration bits 8:0 enable pins 0 to 8. A disabled pin never causes a wake-up and never sets a status bit, and its debounce counter is held at zero.
- R4: Pin configuration bits 24:16 set each pin's active level (0 = low, 1 = high). Counting starts only after the pin has been seen inactive while enabled. Leaving the active level restarts the count. A pin held active fires only once.
- R5: Status bit 0 is set by every pin wake-up and stays set until status (word 2) is read.
- R6: When a pin wake-up fires, status bits 24:16 gain a 1 for each pin that is enabled and at its active level at that moment, or that fired through the slow debouncer.
- R7: Mode bits 17, 18 and 19 let the timer, comparator and receiver pulses cause a wake-up. A comparator wake-up sets status bit 6 and a receiver wake-up sets status bit 7. A pulse whose enable is 0 has no effect.
- R8: Mode bits 1:0 attach pins 0 and 1 to the slow debouncer, and mode bits 10:8 set its length. Code 0 turns it off, and code c (1 to 7) needs c+1 `rtc_tick` pulses while the pin is active. This path does not depend on the pin's enable bit.
- R9: A qualified wake-up event clears `shutdown` and gives `wake_req` = 1 for exactly one cycle, one edge later. If a valid command write arrives in the same cycle as a wake-up event, the wake-up wins.
- R10: A status read returns the old value and clears the register at the same edge. Events that arrive in that same cycle are kept.
- R11: After reset, `shutdown`, `wake_req` and all registers are 0. Mode reads back through mask 0x070E0703 and pin configuration reads back through mask 0x01FF01FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status when word 2 is read) |
| addr | input | 2 | Word select: 0 command, 1 mode, 2 status, 3 pin configuration |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected word (combinational) |
| wk_pins | input | 9 | Asynchronous wake-up pins |
| rtc_tick | input | 1 | Single-cycle time-base tick for the slow debouncer |
| tim_wake | input | 1 | Timer wake-up pulse |
| cmp_wake | input | 1 | Comparator wake-up pulse |
| rx_wake | input | 1 | Low-power receiver wake-up pulse |
| shutdown | output | 1 | Core supply off request |
| wake_req | output | 1 | One-cycle wake-up pulse |

## Verification
The assertions assume that `tim_wake`, `cmp_wake`, `rx_wake` and `rtc_tick` are synchronous to `clk` and last one cycle per event. They also assume that only one of `wr_en` and `rd_en` is active in any cycle. The stimulus changes every input on the falling clock edge, holds each source pulse and tick for exactly one cycle, and never issues a read and a write together. The pins are the only inputs that may change without regard to the clock. The bench toggles them on falling edges too, so the latency of the two-stage synchronizer can be counted exactly.

// File: rtl/shwk_pkg.sv
package shwk_pkg;
  localparam int        CNT_W    = 16;
  localparam int        ADDR_W   = 2;
  localparam logic [7:0] CMD_KEY = 8'hA5;

  localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_PINS = 2'd3;

  localparam int ST_PIN  = 0;
  localparam int ST_CMP  = 6;
  localparam int ST_RX   = 7;
  localparam int HI_FLD  = 16;

  typedef struct packed {
    logic [2:0] dbc_code;
    logic       rx_en;
    logic       cmp_en;
    logic       tim_en;
    logic [2:0] lp_code;
    logic [1:0] lp_sel;
  } mode_t;

  function automatic logic [CNT_W-1:0] dbc_len(input logic [2:0] code);
    case (code)
      3'd0:    dbc_len = 16'd1;
      3'd1:    dbc_len = 16'd3;
      3'd2:    dbc_len = 16'd32;
      3'd3:    dbc_len = 16'd512;
      3'd4:    dbc_len = 16'd4096;
      default: dbc_len = 16'd32768;
    endcase
  endfunction
endpackage

// File: rtl/shwk_pin.sv
module shwk_pin #(
  parameter int CNT_W  = 16,
  parameter int LP_W   = 4,
  parameter bit HAS_LP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             en_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             lp_on_i,
  input  logic [LP_W-1:0]  lp_len_i,
  input  logic             tick_i,
  output logic             fire_o,
  output logic             snap_o
);
  logic s1_q, s2_q, active;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic armed_q, armed_n, main_fire, lp_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign active = (s2_q == pol_i);

  always_comb begin
    main_fire = en_i && armed_q && active && (cnt_q == len_i - 1'b1);
    armed_n   = en_i && (!active || (armed_q && !main_fire));
    if (!en_i || !active || !armed_q || main_fire) cnt_n = '0;
    else                                          cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      armed_q <= armed_n;
    end
  end

  generate
    if (HAS_LP) begin : g_lp
      logic [LP_W-1:0] lcnt_q, lcnt_n;
      logic larm_q, larm_n;
      always_comb begin
        lp_fire = lp_on_i && larm_q && active && tick_i && (lcnt_q == lp_len_i - 1'b1);
        larm_n  = lp_on_i && (!active || (larm_q && !lp_fire));
        lcnt_n  = lcnt_q;
        if (!lp_on_i || !active || !larm_q || lp_fire) lcnt_n = '0;
        else if (tick_i)                               lcnt_n = lcnt_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lcnt_q <= '0;
          larm_q <= 1'b0;
        end else begin
          lcnt_q <= lcnt_n;
          larm_q <= larm_n;
        end
      end
      // one slow-debouncer hit per active episode
      assert_lp_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lp_fire |=> !lp_fire);
    end else begin : g_nolp
      logic unused_lp;
      assign unused_lp = ^{lp_on_i, lp_len_i, tick_i};
      assign lp_fire   = 1'b0;
    end
  endgenerate

  assign fire_o = main_fire | lp_fire;
  assign snap_o = (en_i & active) | lp_fire;

  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
  assert_single_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    main_fire |=> !main_fire);
endmodule

// File: rtl/shwk_regs.sv
module shwk_regs
  import shwk_pkg::*;
#(
  parameter int NPINS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output mode_t             mode_o,
  output logic [NPINS-1:0]  pin_en_o,
  output logic [NPINS-1:0]  pin_pol_o,
  input  logic              pin_evt_i,
  input  logic [NPINS-1:0]  snap_i,
  input  logic              tim_i,
  input  logic              cmp_i,
  input  logic              rx_i,
  output logic              shutdown_o,
  output logic              wake_req_o
);
  mode_t             mode_q, mode_n;
  logic [NPINS-1:0]  en_q, en_n, pol_q, pol_n;
  logic [31:0]       stat_q, stat_n, set_v;
  logic              shut_q, shut_n, wake_q;
  logic              wr_cmd, wr_mode, wr_pins, rd_stat, cmd_ok;
  logic              cmp_evt, rx_evt, wake_evt;
  logic              unused_gap;

  assign unused_gap = ^wdata_i[15:11];

  assign wr_cmd  = wr_en_i && (addr_i == A_CMD);
  assign wr_mode = wr_en_i && (addr_i == A_MODE);
  assign wr_pins = wr_en_i && (addr_i == A_PINS);
  assign rd_stat = rd_en_i && (addr_i == A_STAT);
  assign cmd_ok  = wr_cmd && (wdata_i[31:24] == CMD_KEY) && wdata_i[0];

  assign cmp_evt  = cmp_i && mode_q.cmp_en;
  assign rx_evt   = rx_i && mode_q.rx_en;
  assign wake_evt = pin_evt_i || cmp_evt || rx_evt || (tim_i && mode_q.tim_en);

  always_comb begin
    mode_n = mode_q;
    en_n   = en_q;
    pol_n  = pol_q;
    if (wr_mode) begin
      mode_n.lp_sel   = wdata_i[1:0];
      mode_n.lp_code  = wdata_i[10:8];
      mode_n.tim_en   = wdata_i[17];
      mode_n.cmp_en   = wdata_i[18];
      mode_n.rx_en    = wdata_i[19];
      mode_n.dbc_code = wdata_i[26:24];
    end
    if (wr_pins) begin
      en_n  = wdata_i[NPINS-1:0];
      pol_n = wdata_i[HI_FLD +: NPINS];
    end
    set_v         = '0;
    set_v[ST_PIN] = pin_evt_i;
    set_v[ST_CMP] = cmp_evt;
    set_v[ST_RX]  = rx_evt;
    if (pin_evt_i) set_v[HI_FLD +: NPINS] = snap_i;
    stat_n = (rd_stat ? 32'd0 : stat_q) | set_v;
    shut_n = wake_evt ? 1'b0 : (cmd_ok ? 1'b1 : shut_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
      pol_q  <= '0;
      stat_q <= '0;
      shut_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      en_q   <= en_n;
      pol_q  <= pol_n;
      stat_q <= stat_n;
      shut_q <= shut_n;
      wake_q <= wake_evt;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MODE: begin
        rdata_o[1:0]   = mode_q.lp_sel;
        rdata_o[10:8]  = mode_q.lp_code;
        rdata_o[17]    = mode_q.tim_en;
        rdata_o[18]    = mode_q.cmp_en;
        rdata_o[19]    = mode_q.rx_en;
        rdata_o[26:24] = mode_q.dbc_code;
      end
      A_STAT: rdata_o = stat_q;
      A_PINS: begin
        rdata_o[NPINS-1:0]       = en_q;
        rdata_o[HI_FLD +: NPINS] = pol_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign mode_o     = mode_q;
  assign pin_en_o   = en_q;
  assign pin_pol_o  = pol_q;
  assign shutdown_o = shut_q;
  assign wake_req_o = wake_q;

  assert_bad_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && (wdata_i[31:24] != CMD_KEY) && !wake_evt) |=> $stable(shut_q));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[ST_PIN] && !rd_stat) |=> stat_q[ST_PIN]);
  assert_snap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_evt_i |=> stat_q[ST_PIN]);
  assert_wake_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> !shut_q);
  assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !wake_evt) |=> (stat_q == 32'd0));
endmodule

// File: rtl/shwk_ctrl.sv
module shwk_ctrl
  import shwk_pkg::*;
#(
  parameter int NPINS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NPINS-1:0]  wk_pins,
  input  logic              rtc_tick,
  input  logic              tim_wake,
  input  logic              cmp_wake,
  input  logic              rx_wake,
  output logic              shutdown,
  output logic              wake_req
);
  localparam int LP_PINS = 2;
  localparam int LP_W    = 4;

  mode_t            mode;
  logic [NPINS-1:0] pin_en, pin_pol, fire, snap;
  logic [CNT_W-1:0] dbc_limit;
  logic [LP_W-1:0]  lp_limit;
  logic             lp_active;

  assign dbc_limit = dbc_len(mode.dbc_code);
  assign lp_limit  = {1'b0, mode.lp_code} + 1'b1;
  assign lp_active = (mode.lp_code != 3'd0);

  shwk_regs #(.NPINS(NPINS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .mode_o     (mode),
    .pin_en_o   (pin_en),
    .pin_pol_o  (pin_pol),
    .pin_evt_i  (|fire),
    .snap_i     (snap),
    .tim_i      (tim_wake),
    .cmp_i      (cmp_wake),
    .rx_i       (rx_wake),
    .shutdown_o (shutdown),
    .wake_req_o (wake_req)
  );

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      if (i < LP_PINS) begin : g_slow
        shwk_pin #(.CNT_W(CNT_W), .LP_W(LP_W), .HAS_LP(1'b1)) u_pin (
          .clk      (clk),
          .rst_n    (rst_n),
          .pin_i    (wk_pins[i]),
          .en_i     (pin_en[i]),
          .pol_i    (pin_pol[i]),
          .len_i    (dbc_limit),
          .lp_on_i  (mode.lp_sel[i] && lp_active),
          .lp_len_i (lp_limit),
          .tick_i   (rtc_tick),
          .fire_o   (fire[i]),
          .snap_o   (snap[i])
        );
      end else begin : g_fast
        shwk_pin #(.CNT_W(CNT_W), .LP_W(LP_W), .HAS_LP(1'b0)) u_pin (
          .clk      (clk),
          .rst_n    (rst_n),
          .pin_i    (wk_pins[i]),
          .en_i     (pin_en[i]),
          .pol_i    (pin_pol[i]),
          .len_i    (dbc_limit),
          .lp_on_i  (1'b0),
          .lp_len_i (lp_limit),
          .tick_i   (1'b0),
          .fire_o   (fire[i]),
          .snap_o   (snap[i])
        );
      end
    end
  endgenerate

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !(|fire) && !tim_wake && !cmp_wake && !rx_wake) |=> !wake_req);
endmodule

// File: tb/test_shwk_ctrl.sv
`timescale 1ns/1ps
module test_shwk_ctrl;
  localparam int NP = 9;
  localparam logic [1:0] W_CMD = 2'd0, W_MODE = 2'd1, W_STAT = 2'd2, W_PINS = 2'd3;

  typedef struct packed {
    logic [2:0]  code;
    logic [3:0]  pin;
    logic        pol;
    logic [15:0] n;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 4'd3, 1'b1, 16'd1},
    '{3'd1, 4'd5, 1'b0, 16'd3},
    '{3'd2, 4'd8, 1'b1, 16'd32},
    '{3'd3, 4'd2, 1'b0, 16'd512},
    '{3'd4, 4'd7, 1'b1, 16'd4096},
    '{3'd5, 4'd4, 1'b0, 16'd32768},
    '{3'd7, 4'd3, 1'b0, 16'd32768}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, tmp;
  logic [NP-1:0] pins = '0;
  logic rtc_tick = 1'b0, tim_wake = 1'b0, cmp_wake = 1'b0, rx_wake = 1'b0;
  logic shutdown, wake_req, seen;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  shwk_ctrl #(.NPINS(NP)) i_shwk_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wk_pins(pins), .rtc_tick(rtc_tick),
    .tim_wake(tim_wake), .cmp_wake(cmp_wake), .rx_wake(rx_wake),
    .shutdown(shutdown), .wake_req(wake_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sel: 0 timer, 1 comparator, 2 receiver, 3 tick
  task automatic pulse(input int sel);
    @(negedge clk);
    case (sel)
      0: tim_wake = 1'b1;
      1: cmp_wake = 1'b1;
      2: rx_wake  = 1'b1;
      default: rtc_tick = 1'b1;
    endcase
    @(negedge clk);
    tim_wake = 1'b0; cmp_wake = 1'b0; rx_wake = 1'b0; rtc_tick = 1'b0;
  endtask

  task automatic watch_quiet(input int n);
    seen = 1'b0;
    repeat (n) begin @(negedge clk); seen |= wake_req; end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    check("R11 shutdown", {31'b0, shutdown}, 32'd0);
    check("R11 wake_req", {31'b0, wake_req}, 32'd0);
    rd(W_MODE, tmp); check("R11 mode", tmp, 32'd0);
    rd(W_PINS, tmp); check("R11 pins", tmp, 32'd0);
    rd(W_STAT, tmp); check("R11 status", tmp, 32'd0);
    // R1 key protection
    wr(W_CMD, 32'h5A00_0001); check("R1 bad key", {31'b0, shutdown}, 32'd0);
    wr(W_CMD, 32'hA500_0000); check("R1 bit0 clear", {31'b0, shutdown}, 32'd0);
    rd(W_CMD, tmp); check("R1 cmd reads 0", tmp, 32'd0);
    // R11 readback masks
    wr(W_MODE, 32'hFFFF_FFFF); rd(W_MODE, tmp); check("R11 mode mask", tmp, 32'h070E_0703);
    wr(W_PINS, 32'hFFFF_FFFF); rd(W_PINS, tmp); check("R11 pins mask", tmp, 32'h01FF_01FF);
    wr(W_PINS, 32'd0); wr(W_MODE, 32'd0);

    // R2 vector table
    for (int v = 0; v < NV; v++) begin
      pins[VEC[v].pin] = ~VEC[v].pol;
      wr(W_PINS, (32'd1 << VEC[v].pin) | (32'(VEC[v].pol) << (16 + VEC[v].pin)));
      wr(W_MODE, 32'(VEC[v].code) << 24);
      rd(W_STAT, tmp);
      idle(4);
      wr(W_CMD, 32'hA500_0001);
      check("R1 shutdown set", {31'b0, shutdown}, 32'd1);
      pins[VEC[v].pin] = VEC[v].pol;
      repeat (int'(VEC[v].n) + 1) @(posedge clk);
      @(negedge clk);
      check("R2 not before N", {31'b0, wake_req}, 32'd0);
      check("R2 shutdown held", {31'b0, shutdown}, 32'd1);
      @(posedge clk); @(negedge clk);
      check("R2 wake at N", {31'b0, wake_req}, 32'd1);
      check("R9 shutdown cleared", {31'b0, shutdown}, 32'd0);
      watch_quiet(6);
      check("R4 held level fires once", {31'b0, seen}, 32'd0);
      rd(W_STAT, tmp);
      check("R6 snapshot", tmp, 32'd1 | (32'd1 << (16 + VEC[v].pin)));
      rd(W_STAT, tmp);
      check("R5 cleared by read", tmp, 32'd0);
      pins[VEC[v].pin] = ~VEC[v].pol;
    end

    // R3 disabled pin
    wr(W_MODE, 32'd0);
    pins[6] = 1'b0;
    wr(W_PINS, 32'h0040_0000);
    idle(4);
    pins[6] = 1'b1;
    watch_quiet(8);
    check("R3 disabled no wake", {31'b0, seen}, 32'd0);
    rd(W_STAT, tmp); check("R3 disabled no status", tmp, 32'd0);
    // R4 already active when enabled: no edge, no wake
    wr(W_PINS, 32'h0040_0040);
    watch_quiet(8);
    check("R4 needs edge", {31'b0, seen}, 32'd0);
    pins[6] = 1'b0; idle(4);
    pins[6] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R4 edge then level early", {31'b0, wake_req}, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R4 edge then level", {31'b0, wake_req}, 32'd1);
    // R4 restart after short glitch, N = 3
    wr(W_MODE, 32'h0100_0000);
    pins[6] = 1'b0; idle(4);
    pins[6] = 1'b1; idle(2); pins[6] = 1'b0;
    watch_quiet(8);
    check("R4 glitch ignored", {31'b0, seen}, 32'd0);
    pins[6] = 1'b1;
    repeat (4) @(posedge clk); @(negedge clk);
    check("R4 restarted count early", {31'b0, wake_req}, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R4 restarted count", {31'b0, wake_req}, 32'd1);
    pins[6] = 1'b0;
    wr(W_PINS, 32'd0);
    rd(W_STAT, tmp);

    // R7 internal sources
    wr(W_MODE, 32'h0004_0000);
    pulse(1); check("R7 comparator wake", {31'b0, wake_req}, 32'd1);
    pulse(2); check("R7 receiver disabled", {31'b0, wake_req}, 32'd0);
    rd(W_STAT, tmp); check("R7 comparator flag", tmp, 32'h0000_0040);
    wr(W_MODE, 32'h000A_0000);
    pulse(2); check("R7 receiver wake", {31'b0, wake_req}, 32'd1);
    pulse(0); check("R7 timer wake", {31'b0, wake_req}, 32'd1);
    pulse(1); check("R7 comparator disabled", {31'b0, wake_req}, 32'd0);
    rd(W_STAT, tmp); check("R7 receiver flag", tmp, 32'h0000_0080);

    // R9 shutdown/wake interplay and priority
    wr(W_CMD, 32'hA500_0001); check("R9 armed", {31'b0, shutdown}, 32'd1);
    pulse(0);
    check("R9 timer clears", {31'b0, shutdown}, 32'd0);
    check("R9 pulse", {31'b0, wake_req}, 32'd1);
    @(negedge clk); check("R9 one cycle", {31'b0, wake_req}, 32'd0);
    @(negedge clk);
    wr_en = 1'b1; addr = W_CMD; wdata = 32'hA500_0001; tim_wake = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tim_wake = 1'b0;
    check("R9 wake wins", {31'b0, shutdown}, 32'd0);

    // R10 read-clear with same-cycle event
    wr(W_MODE, 32'h0004_0000);
    rd(W_STAT, tmp);
    @(negedge clk);
    rd_en = 1'b1; addr = W_STAT; cmp_wake = 1'b1;
    #1 tmp = rdata;
    @(negedge clk);
    rd_en = 1'b0; cmp_wake = 1'b0;
    check("R10 returned old value", tmp, 32'd0);
    rd(W_STAT, tmp); check("R10 event kept", tmp, 32'h0000_0040);

    // R8 slow debouncer on pin 0, code 1 -> 2 ticks
    pins[0] = 1'b0;
    wr(W_PINS, 32'h0001_0000);
    wr(W_MODE, 32'h0000_0101);
    rd(W_STAT, tmp);
    idle(4);
    pins[0] = 1'b1;
    watch_quiet(5);
    check("R8 no tick no wake", {31'b0, seen}, 32'd0);
    pulse(3); check("R8 first tick", {31'b0, wake_req}, 32'd0);
    pulse(3); check("R8 second tick", {31'b0, wake_req}, 32'd1);
    rd(W_STAT, tmp); check("R8 status", tmp, 32'h0001_0001);
    pins[0] = 1'b0;

    idle(2);
    finish_run();
  end
endmodule